// File: doc/BRIEF.md
# Synchronous Burst-Read Mask ROM

This block is a clocked, read-only memory with a shared row/column address bus. It answers commands sampled on the rising clock edge. The caller first opens a row with a row strobe. After the programmed row latency it issues a column strobe. A burst of words then comes back, starting a programmed column latency later and advancing one word per cycle. A mode command loads the row latency, column latency, burst length and burst order from the address bus.

A level input selects the organisation at each column command. In 16-bit mode the column address has 9 bits and only the low half of the data bus carries data. In 32-bit mode the column has 8 bits and both halves are used. Either way the same array of 2^22 half-words is covered. The contents are produced by a fixed arithmetic function of the address, so no stored table or file is needed.

A mask input blanks single data cycles of a burst without stalling it. A column command issued too soon after the row command is dropped and flagged.

Top module: `sync_burst_rom`

## Requirements
- R1: After reset, dataOe and errFlag are low and dataOut is zero. The mode register holds row latency 2, column latency 5, burst length 4 and sequential order.
- R2: When csEn and modeCmd are both high in a cycle, the mode register loads from addr. addr[0] is the row latency (0 gives 1, 1 gives 2). addr[2:1] is the column latency minus 3. addr[3] is the burst length (0 gives 4, 1 gives 8). addr[4] is the order (0 sequential, 1 interleaved). If several command inputs are high together, modeCmd wins over rowCmd, and rowCmd wins over colCmd.
- R3: A column command accepted in cycle c returns burst words in cycles c+CL through c+CL+BL-1, with dataOe high, and dataOe is low again in cycle c+CL+BL. A column command given at the earliest allowed cycle therefore yields its first word RL+CL cycles after the row command.
- R4: In sequential order, beat k reads the column whose low log2(BL) bits are (start + k) mod BL; the upper column bits stay unchanged.
- R5: In interleaved order, beat k reads the column whose low log2(BL) bits are start XOR k; the upper column bits stay unchanged.
- R6: With wordMode high, the column is addr[8:0] and dataOut = {16'h0, H({row,col})}. With wordMode low, the column is addr[7:0] (addr[8] is ignored) and dataOut = {H({row,col,1'b1}), H({row,col,1'b0})}. Here H(a) = {a[7:0],a[15:8]} ^ a[21:16] ^ 16'h5A3C, for a 22-bit a.
- R7: dqm high in cycle m forces dataOe low and dataOut to zero in cycle m+2. The burst still advances, so the next unmasked beat reads its own column.
- R8: A column command is ignored if it comes fewer than RL cycles after the last row command, or before any row command since reset. Such a command raises errFlag in the next cycle only.
- R9: A column command accepted while a burst is pending or running ends that burst. No word of the old burst appears after the command cycle, and the new burst follows the timing of R3.
- R10: When csEn is low, all command inputs are ignored, and a burst already in progress continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every input is sampled on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| csEn | input | 1 | Select; commands are decoded only while it is high |
| rowCmd | input | 1 | Row strobe: opens the row on addr |
| colCmd | input | 1 | Column strobe: starts a burst at the column on addr |
| modeCmd | input | 1 | Mode-register load from addr[4:0] |
| wordMode | input | 1 | 1 = 16-bit organisation, 0 = 32-bit, taken at the column command |
| dqm | input | 1 | Output mask for the data cycle two cycles later |
| addr | input | ROW_W (13) | Multiplexed row / column / mode-key bus |
| dataOut | output | 2*HALF_W (32) | Read data, zero when not enabled |
| dataOe | output | 1 | Output enable (low models the high-impedance state) |
| errFlag | output | 1 | One-cycle flag for a column command that came too early |

## Verification
The risky overlap is a new column command that lands in the same cycle as a word the running burst is about to present. The bench issues the second column command in the cycle where the first burst shows its second word. It expects that word in the command cycle, then a blank output through the new column latency, then the new burst from its own column. A second overlap is a mask pulse placed inside a burst. The bench judges it by a blank cycle exactly two cycles after the pulse, with the following beat still at its own address.

// File: rtl/sbrom_pkg.sv
package sbrom_pkg;
  localparam int MODE_W = 5;
  localparam int BEAT_W = 3;

  typedef struct packed {
    logic                loadRow;
    logic                loadCol;
    logic                emit;
    logic [BEAT_W-1:0]   beat;
    logic                blLong;
    logic                ilv;
  } strobe_t;
endpackage

// File: rtl/sbrom_ctrl.sv
module sbrom_ctrl
  import sbrom_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              csEn,
  input  logic              rowCmd,
  input  logic              colCmd,
  input  logic              modeCmd,
  input  logic [MODE_W-1:0] modeKey,
  output strobe_t           stb,
  output logic              errFlag
);
  // key layout: [0] row latency-1, [2:1] column latency-3, [3] length 8, [4] interleave
  localparam logic [MODE_W-1:0] MODE_RESET = 5'b00101;

  logic [MODE_W-1:0] modeReg;
  logic              isMode, isRow, isCol, colOk, colAccept, colEarly;
  logic [1:0]        rowLat, rowAge;
  logic              rowOpen;
  logic [2:0]        colLat, waitCnt;
  logic              busy, fire, curLong, curIlv;
  logic [BEAT_W-1:0] beat, lastBeat;

  always_comb begin
    isMode    = csEn & modeCmd;
    isRow     = csEn & rowCmd & ~modeCmd;
    isCol     = csEn & colCmd & ~modeCmd & ~rowCmd;
    rowLat    = modeReg[0] ? 2'd2 : 2'd1;
    colLat    = 3'd3 + {1'b0, modeReg[2:1]};
    colOk     = rowOpen && (rowAge >= rowLat);
    colAccept = isCol & colOk;
    colEarly  = isCol & ~colOk;
    fire      = (waitCnt == 3'd1);
    lastBeat  = curLong ? BEAT_W'(7) : BEAT_W'(3);

    stb.loadRow = isRow;
    stb.loadCol = colAccept;
    stb.emit    = (fire | busy) & ~colAccept;
    stb.beat    = busy ? beat : '0;
    stb.blLong  = curLong;
    stb.ilv     = curIlv;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      modeReg <= MODE_RESET;
      rowOpen <= 1'b0;
      rowAge  <= 2'd0;
      waitCnt <= 3'd0;
      busy    <= 1'b0;
      beat    <= '0;
      curLong <= 1'b0;
      curIlv  <= 1'b0;
      errFlag <= 1'b0;
    end else begin
      errFlag <= colEarly;
      if (isMode) modeReg <= modeKey;

      if (isRow) begin
        rowOpen <= 1'b1;
        rowAge  <= 2'd1;
      end else if (rowAge != 2'd3) begin
        rowAge <= rowAge + 2'd1;
      end

      if (fire) begin
        waitCnt <= 3'd0;
        busy    <= 1'b1;
        beat    <= BEAT_W'(1);
      end else if (waitCnt != 3'd0) begin
        waitCnt <= waitCnt - 3'd1;
      end else if (busy) begin
        if (beat == lastBeat) busy <= 1'b0;
        else                  beat <= beat + BEAT_W'(1);
      end

      if (colAccept) begin
        waitCnt <= colLat - 3'd1;
        busy    <= 1'b0;
        beat    <= '0;
        curLong <= modeReg[3];
        curIlv  <= modeReg[4];
      end
    end
  end
endmodule

// File: rtl/sbrom_datapath.sv
module sbrom_datapath
  import sbrom_pkg::*;
#(
  parameter int ROW_W  = 13,
  parameter int COL_W  = 9,
  parameter int HALF_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  strobe_t             stb,
  input  logic                wordMode,
  input  logic                dqm,
  input  logic [ROW_W-1:0]    addr,
  output logic [2*HALF_W-1:0] dataOut,
  output logic                dataOe
);
  localparam int AW = ROW_W + COL_W;
  localparam logic [HALF_W-1:0] SEED = HALF_W'(16'h5A3C);

  function automatic logic [HALF_W-1:0] romHalf(input logic [AW-1:0] a);
    logic [HALF_W-1:0] lo;
    lo = a[HALF_W-1:0];
    return {lo[HALF_W/2-1:0], lo[HALF_W-1:HALF_W/2]} ^ HALF_W'(a >> HALF_W) ^ SEED;
  endfunction

  logic [ROW_W-1:0]  openRow, burstRow;
  logic [COL_W-1:0]  burstCol, beatCol, maskW, stepped;
  logic              burstX16, maskD1, show;
  logic [HALF_W-1:0] laneWord [2];

  always_ff @(posedge clk) begin
    if (rst) begin
      openRow  <= '0;
      burstRow <= '0;
      burstCol <= '0;
      burstX16 <= 1'b1;
    end else begin
      if (stb.loadRow) openRow <= addr;
      if (stb.loadCol) begin
        burstRow <= openRow;
        burstCol <= wordMode ? addr[COL_W-1:0] : {1'b0, addr[COL_W-2:0]};
        burstX16 <= wordMode;
      end
    end
  end

  always_comb begin
    maskW   = stb.blLong ? COL_W'(7) : COL_W'(3);
    stepped = stb.ilv ? (burstCol ^ COL_W'(stb.beat)) : (burstCol + COL_W'(stb.beat));
    beatCol = (burstCol & ~maskW) | (stepped & maskW);
  end

  for (genvar lane = 0; lane < 2; lane++) begin : g_lane
    logic [AW-1:0] laneAddr;
    assign laneAddr = burstX16 ? {burstRow, beatCol}
                               : {burstRow, beatCol[COL_W-2:0], 1'(lane)};
    assign laneWord[lane] = (burstX16 && lane == 1) ? '0 : romHalf(laneAddr);
  end

  assign show = stb.emit & ~maskD1;

  always_ff @(posedge clk) maskD1 <= dqm;

  always_ff @(posedge clk) begin
    if (rst) begin
      dataOe  <= 1'b0;
      dataOut <= '0;
    end else begin
      dataOe  <= show;
      dataOut <= show ? {laneWord[1], laneWord[0]} : '0;
    end
  end
endmodule

// File: rtl/sync_burst_rom.sv
module sync_burst_rom
  import sbrom_pkg::*;
#(
  parameter int ROW_W  = 13,
  parameter int COL_W  = 9,
  parameter int HALF_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                csEn,
  input  logic                rowCmd,
  input  logic                colCmd,
  input  logic                modeCmd,
  input  logic                wordMode,
  input  logic                dqm,
  input  logic [ROW_W-1:0]    addr,
  output logic [2*HALF_W-1:0] dataOut,
  output logic                dataOe,
  output logic                errFlag
);
  strobe_t stb;

  sbrom_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .csEn    (csEn),
    .rowCmd  (rowCmd),
    .colCmd  (colCmd),
    .modeCmd (modeCmd),
    .modeKey (addr[MODE_W-1:0]),
    .stb     (stb),
    .errFlag (errFlag)
  );

  sbrom_datapath #(
    .ROW_W  (ROW_W),
    .COL_W  (COL_W),
    .HALF_W (HALF_W)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .stb      (stb),
    .wordMode (wordMode),
    .dqm      (dqm),
    .addr     (addr),
    .dataOut  (dataOut),
    .dataOe   (dataOe)
  );
endmodule

// File: rtl/sbrom_checker.sv
module sbrom_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              csEn,
  input logic              rowCmd,
  input logic              colCmd,
  input logic              modeCmd,
  input logic              dqm,
  input logic [DATA_W-1:0] dataOut,
  input logic              dataOe,
  input logic              errFlag
);
  logic [1:0] age;
  logic [3:0] runLen;

  always_ff @(posedge clk) begin
    if (rst) begin
      age    <= 2'd0;
      runLen <= 4'd0;
    end else begin
      if (age != 2'd3) age <= age + 2'd1;
      if (!dataOe)               runLen <= 4'd0;
      else if (runLen != 4'd15)  runLen <= runLen + 4'd1;
    end
  end

  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!dataOe && !errFlag));

  p_burst_bound_r3: assert property (@(posedge clk) disable iff (rst)
    runLen <= 4'd8);

  p_mask_blank_r7: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd3 && $past(dqm, 2)) |-> !dataOe);

  p_idle_zero_r7: assert property (@(posedge clk) disable iff (rst)
    !dataOe |-> (dataOut == '0));

  p_err_cause_r8: assert property (@(posedge clk) disable iff (rst)
    errFlag |-> $past(csEn && colCmd && !rowCmd && !modeCmd));
endmodule

bind sync_burst_rom sbrom_checker #(.DATA_W(2*HALF_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .csEn    (csEn),
  .rowCmd  (rowCmd),
  .colCmd  (colCmd),
  .modeCmd (modeCmd),
  .dqm     (dqm),
  .dataOut (dataOut),
  .dataOe  (dataOe),
  .errFlag (errFlag)
);

// File: tb/sync_burst_rom_tb.sv
module sync_burst_rom_tb;
  logic        clk = 1'b0;
  logic        rst, csEn, rowCmd, colCmd, modeCmd, wordMode, dqm;
  logic [12:0] addr;
  logic [31:0] dataOut;
  logic        dataOe, errFlag;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  sync_burst_rom u_dut (
    .clk(clk), .rst(rst), .csEn(csEn), .rowCmd(rowCmd), .colCmd(colCmd),
    .modeCmd(modeCmd), .wordMode(wordMode), .dqm(dqm), .addr(addr),
    .dataOut(dataOut), .dataOe(dataOe), .errFlag(errFlag)
  );

  typedef struct packed {
    logic [4:0]  key;
    logic        wm;
    logic [12:0] row;
    logic [8:0]  col;
    int          maskBeat;
    int          expFirst;
  } vec_t;

  // key, organisation, row, column, masked beat, expected row-to-first-word cycles
  localparam vec_t VECS [5] = '{
    '{5'b00000, 1'b1, 13'h00A5, 9'h1FE, -1, 4},
    '{5'b01010, 1'b0, 13'h1234, 9'h1FD,  3, 5},
    '{5'b11111, 1'b1, 13'h1FFF, 9'h105, -1, 8},
    '{5'b10101, 1'b0, 13'h0000, 9'h0AB,  1, 7},
    '{5'b00011, 1'b1, 13'h0ABC, 9'h003,  3, 6}
  };

  function automatic logic [15:0] hw(input logic [21:0] a);
    return {a[7:0], a[15:8]} ^ {10'h0, a[21:16]} ^ 16'h5A3C;
  endfunction

  function automatic logic [31:0] expWord(input bit wm, input logic [12:0] row,
                                          input logic [8:0] col, input int beat,
                                          input bit bl8, input bit ilv);
    logic [8:0] base, m, lo, cc;
    base = wm ? col : {1'b0, col[7:0]};
    m    = bl8 ? 9'd7 : 9'd3;
    lo   = ilv ? ((base ^ 9'(beat)) & m) : ((base + 9'(beat)) & m);
    cc   = (base & ~m) | lo;
    if (wm) return {16'h0, hw({row, cc})};
    return {hw({row, cc[7:0], 1'b1}), hw({row, cc[7:0], 1'b0})};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic idle();
    csEn = 1'b1; rowCmd = 1'b0; colCmd = 1'b0; modeCmd = 1'b0; dqm = 1'b0; addr = '0;
  endtask

  task automatic doReset();
    rst = 1'b1; idle(); wordMode = 1'b1;
    repeat (3) tick();
    rst = 1'b0;
  endtask

  task automatic setMode(input logic [4:0] key);
    tick(); idle(); modeCmd = 1'b1; addr = {8'h0, key};
  endtask

  // Open row, give column at the earliest cycle, then watch the whole burst.
  task automatic readBurst(input bit doMode, input logic [4:0] key, input bit wm,
                           input logic [12:0] row, input logic [8:0] col,
                           input int maskBeat, input int expFirst, input int csGlitchK,
                           input string tag);
    int rl, cl, bl, firstK, beat;
    rl = key[0] ? 2 : 1;
    cl = 3 + int'(key[2:1]);
    bl = key[3] ? 8 : 4;
    firstK = -1;
    if (doMode) setMode(key);
    tick(); idle(); rowCmd = 1'b1; addr = row;
    repeat (rl - 1) begin tick(); idle(); end
    tick(); idle(); colCmd = 1'b1; addr = {4'h0, col}; wordMode = wm;
    for (int k = 1; k <= cl + bl; k++) begin
      tick();
      beat = k - cl;
      if (k < cl || k == cl + bl)
        chk({tag, " idle outside burst R3"}, {31'h0, dataOe, dataOut}, 64'h0);
      else if (beat == maskBeat)
        chk({tag, " masked beat R7"}, {31'h0, dataOe, dataOut}, 64'h0);
      else
        chk({tag, " burst word R4 R5 R6"}, {31'h0, dataOe, dataOut},
            {31'h0, 1'b1, expWord(wm, row, col, beat, key[3], key[4])});
      if (dataOe && firstK < 0) firstK = k;
      idle();
      dqm = (maskBeat >= 0 && k == cl + maskBeat - 2);
      if (k == csGlitchK) begin
        csEn = 1'b0; modeCmd = 1'b1; rowCmd = 1'b1; colCmd = 1'b1; addr = 13'h001F;
      end
    end
    chk({tag, " first-word latency R3"}, 64'(rl + firstK), 64'(expFirst));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R3 watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    doReset();
    tick();
    // R1: outputs quiet after reset
    chk("R1 reset outputs", {31'h0, dataOe, errFlag, dataOut}, 64'h0);
    // R1: default mode, latency 2+5, burst 4, sequential
    readBurst(0, 5'b00101, 1'b1, 13'h0777, 9'h0C2, -1, 7, -1, "R1 default mode");

    // R2: table of mode keys and read patterns
    for (int i = 0; i < 5; i++)
      readBurst(1, VECS[i].key, VECS[i].wm, VECS[i].row, VECS[i].col,
                VECS[i].maskBeat, VECS[i].expFirst, -1, "R2 table");

    // R2: mode wins over row in the same cycle, so no row is open afterwards
    doReset();
    tick(); idle(); modeCmd = 1'b1; rowCmd = 1'b1; addr = 13'h0000;
    tick(); idle();
    tick(); idle(); colCmd = 1'b1; addr = 13'h0005;
    tick(); chk("R2 priority leaves row closed", {63'h0, errFlag}, 64'h1); idle();
    tick(); chk("R8 flag lasts one cycle", {63'h0, errFlag}, 64'h0);

    // R9: second column during a burst
    setMode(5'b00101);
    tick(); idle(); rowCmd = 1'b1; addr = 13'h0321;
    tick(); idle();
    tick(); idle(); colCmd = 1'b1; addr = 13'h0010;
    for (int k = 1; k <= 15; k++) begin
      tick();
      if (k == 5 || k == 6)
        chk("R9 old burst word", {31'h0, dataOe, dataOut},
            {31'h0, 1'b1, expWord(1'b1, 13'h0321, 9'h010, k - 5, 1'b0, 1'b0)});
      else if (k >= 11 && k <= 14)
        chk("R9 new burst word", {31'h0, dataOe, dataOut},
            {31'h0, 1'b1, expWord(1'b1, 13'h0321, 9'h020, k - 11, 1'b0, 1'b0)});
      else
        chk("R9 gap", {31'h0, dataOe, dataOut}, 64'h0);
      idle();
      if (k == 6) begin colCmd = 1'b1; addr = 13'h0020; end
    end

    // R8: column one cycle after row with row latency 2
    tick(); idle(); rowCmd = 1'b1; addr = 13'h0444;
    tick(); idle(); colCmd = 1'b1; addr = 13'h0011;
    tick(); chk("R8 early column flagged", {63'h0, errFlag}, 64'h1); idle();
    for (int k = 0; k < 10; k++) begin
      tick();
      chk("R8 early column ignored", {31'h0, dataOe, dataOut}, 64'h0);
    end

    // R10: deselected commands during a burst change nothing
    readBurst(0, 5'b00101, 1'b1, 13'h0555, 9'h0A1, -1, 7, 2, "R10 deselected");
    readBurst(0, 5'b00101, 1'b0, 13'h0666, 9'h0F0, -1, 7, -1, "R10 mode kept");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule